// File: doc/BRIEF.md
# Byte and Halfword Swap Unit

A registered data-rearrangement unit for the execute stage of a processor. One operand word and a 2-bit operation code arrive with a valid strobe. One clock later the unit returns the rearranged word, a fresh set of four condition flags (zero, sign, carry, overflow) and its own valid strobe. The word is split into four equal lanes, each one byte wide by default. The three operations swap the lanes within each halfword, reverse all four lanes, or swap the two halfwords.

The carry flag acts as a zero-lane detector, and what it looks for depends on the operation. After a full lane reversal it reports that some byte of the result is zero. After either of the other two operations it reports that one halfword of the result is zero. The fourth operation code is reserved. It passes the operand through and keeps the flags the unit already holds.

Top module: `lane_swap_unit`

## Requirements
- R1: Operation code 2'b00 returns the operand with bits 31:24 exchanged with 23:16 and bits 15:8 exchanged with 7:0.
- R2: Operation code 2'b01 returns the operand with its byte order fully reversed: byte 3 of the operand becomes byte 0 of the result, byte 0 becomes byte 3, byte 2 becomes byte 1, and byte 1 becomes byte 2.
- R3: Operation code 2'b10 returns the operand with bits 31:16 and bits 15:0 exchanged.
- R4: Operation code 2'b11 returns the operand unchanged and leaves all four flag outputs at their previous values.
- R5: For codes 2'b00 to 2'b10, the zero flag is 1 exactly when the whole 32-bit result is zero.
- R6: For codes 2'b00 to 2'b10, the sign flag equals bit 31 of the result.
- R7: For code 2'b01, the carry flag is 1 exactly when at least one of the four result bytes is zero.
- R8: For codes 2'b00 and 2'b10, the carry flag is 1 exactly when the upper or the lower halfword of the result is zero. A single zero byte inside a non-zero halfword does not set it.
- R9: The overflow flag is always 0.
- R10: Results and out_valid appear on the clock edge after the one that accepts in_valid. If in_valid is low, out_valid is low on the next cycle and the data and flag outputs keep their values.
- R11: While rst_n is low, out_valid, out_data and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and operation code are valid this cycle |
| in_op | input | 2 | Operation code: 00 lane swap within halfwords, 01 full reversal, 10 halfword swap, 11 reserved |
| in_data | input | 32 | Operand word |
| out_valid | output | 1 | Result is valid, one cycle after acceptance |
| out_data | output | 32 | Rearranged word |
| out_zero | output | 1 | Zero flag |
| out_sign | output | 1 | Sign flag |
| out_carry | output | 1 | Carry flag (zero-lane detector) |
| out_ovf | output | 1 | Overflow flag |

## Verification
The bench builds two instances, both with the default lane width of 8, which gives a 32-bit word. One uses the arithmetic zero-byte detector (ZDET_ARITH=1) and the other uses the per-lane comparator variant (ZDET_ARITH=0). Both are checked against the same expected values. Every vector therefore exercises each variant of the carry logic. Operands with a single zero byte inside a non-zero halfword separate the byte rule from the halfword rule. Vectors with bytes of value 0x01 and 0x80 test the subtraction trick where borrows can run into the next byte.

// File: rtl/lane_swap_pkg.sv
package lane_swap_pkg;

   typedef enum logic [1:0] {
      SWP_HALF_LANES = 2'b00,
      SWP_WORD_REV   = 2'b01,
      SWP_HALVES     = 2'b10,
      SWP_RESERVED   = 2'b11
   } swp_op_e;

   typedef struct packed {
      logic z;
      logic s;
      logic cy;
      logic ov;
   } swp_flags_t;

   localparam int unsigned SWP_LANES = 4;

endpackage

// File: rtl/lane_swap_xbar.sv
module lane_swap_xbar
   import lane_swap_pkg::*;
#(
   parameter int unsigned LANE_W = 8
) (
   input  swp_op_e                           op,
   input  logic [SWP_LANES*LANE_W-1:0]       din,
   output logic [SWP_LANES*LANE_W-1:0]       dout
);
   localparam int unsigned WORD_W = SWP_LANES * LANE_W;

   logic [LANE_W-1:0] lane_in [SWP_LANES];
   logic [1:0]        sel_mask;

   // The source lane is the destination index XORed with a mask per operation.
   always_comb begin
      unique case (op)
         SWP_HALF_LANES: sel_mask = 2'b01;
         SWP_WORD_REV:   sel_mask = 2'b11;
         SWP_HALVES:     sel_mask = 2'b10;
         default:        sel_mask = 2'b00;
      endcase
   end

   for (genvar i = 0; i < SWP_LANES; i++) begin : g_lane
      assign lane_in[i] = din[i*LANE_W +: LANE_W];
      assign dout[i*LANE_W +: LANE_W] = lane_in[2'(i) ^ sel_mask];
   end

   if (WORD_W != 4 * LANE_W) begin : g_bad_word
      $error("lane_swap_xbar: word must hold exactly four lanes");
   end

endmodule

// File: rtl/lane_swap_flags.sv
module lane_swap_flags
   import lane_swap_pkg::*;
#(
   parameter int unsigned LANE_W     = 8,
   parameter bit          ZDET_ARITH = 1'b1
) (
   input  swp_op_e                      op,
   input  logic [SWP_LANES*LANE_W-1:0]  res,
   input  swp_flags_t                   prev,
   output swp_flags_t                   nxt
);
   localparam int unsigned WORD_W = SWP_LANES * LANE_W;
   localparam int unsigned HALF_W = WORD_W / 2;
   localparam logic [LANE_W-1:0] LANE_ONE = LANE_W'(1);
   localparam logic [LANE_W-1:0] LANE_MSB = LANE_W'(1) << (LANE_W - 1);
   localparam logic [WORD_W-1:0] ONES_REP = {SWP_LANES{LANE_ONE}};
   localparam logic [WORD_W-1:0] MSBS_REP = {SWP_LANES{LANE_MSB}};

   logic lane_hit;
   logic half_hit;

   if (ZDET_ARITH) begin : g_zdet_arith
      logic [WORD_W-1:0] borrow_mix;
      assign borrow_mix = (res - ONES_REP) & ~res & MSBS_REP;
      assign lane_hit   = |borrow_mix;
   end else begin : g_zdet_cmp
      logic [SWP_LANES-1:0] lane_zero;
      for (genvar i = 0; i < SWP_LANES; i++) begin : g_cmp
         assign lane_zero[i] = (res[i*LANE_W +: LANE_W] == '0);
      end
      assign lane_hit = |lane_zero;
   end

   assign half_hit = (res[WORD_W-1:HALF_W] == '0) || (res[HALF_W-1:0] == '0);

   always_comb begin
      if (op == SWP_RESERVED) begin
         nxt = prev;
      end else begin
         nxt.z  = (res == '0);
         nxt.s  = res[WORD_W-1];
         nxt.cy = (op == SWP_WORD_REV) ? lane_hit : half_hit;
         nxt.ov = 1'b0;
      end
   end

   if (LANE_W < 2) begin : g_bad_lane
      $error("lane_swap_flags: LANE_W must be at least 2");
   end

endmodule

// File: rtl/lane_swap_unit.sv
module lane_swap_unit
   import lane_swap_pkg::*;
#(
   parameter int unsigned LANE_W     = 8,
   parameter bit          ZDET_ARITH = 1'b1,
   localparam int unsigned WORD_W    = SWP_LANES * LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [WORD_W-1:0] in_data,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_zero,
   output logic              out_sign,
   output logic              out_carry,
   output logic              out_ovf
);
   swp_op_e           op_q;
   logic [WORD_W-1:0] perm_data;
   swp_flags_t        flags_q;
   swp_flags_t        flags_d;

   assign op_q = swp_op_e'(in_op);

   lane_swap_xbar #(.LANE_W(LANE_W)) u_xbar (
      .op   (op_q),
      .din  (in_data),
      .dout (perm_data)
   );

   lane_swap_flags #(.LANE_W(LANE_W), .ZDET_ARITH(ZDET_ARITH)) u_flags (
      .op   (op_q),
      .res  (perm_data),
      .prev (flags_q),
      .nxt  (flags_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         flags_q   <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            out_data <= perm_data;
            flags_q  <= flags_d;
         end
      end
   end

   assign out_zero  = flags_q.z;
   assign out_sign  = flags_q.s;
   assign out_carry = flags_q.cy;
   assign out_ovf   = flags_q.ov;

endmodule

// File: rtl/lane_swap_unit_chk.sv
module lane_swap_unit_chk #(
   parameter int unsigned WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        in_op,
   input logic [WORD_W-1:0] in_data,
   input logic              out_valid,
   input logic [WORD_W-1:0] out_data,
   input logic              out_zero,
   input logic              out_sign,
   input logic              out_carry,
   input logic              out_ovf
);
   p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_ovf);

   p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_idle_no_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(out_data) && $stable({out_zero, out_sign, out_carry}));

   p_rsvd_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b11) |=> out_data == $past(in_data));

   p_rsvd_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op == 2'b11) |=> $stable({out_zero, out_sign, out_carry, out_ovf}));

   p_zero_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op != 2'b11) |=> out_zero == (out_data == '0));

   p_sign_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_op != 2'b11) |=> out_sign == out_data[WORD_W-1]);

   p_reset_clear_r11: assert property (@(posedge clk)
      !rst_n |-> !out_valid && out_data == '0 && !out_zero && !out_carry);

endmodule

bind lane_swap_unit lane_swap_unit_chk #(.WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_op     (in_op),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_data  (out_data),
   .out_zero  (out_zero),
   .out_sign  (out_sign),
   .out_carry (out_carry),
   .out_ovf   (out_ovf)
);

// File: tb/test_lane_swap_unit.sv
module test_lane_swap_unit;

   typedef struct {
      logic [31:0] data;
      logic        z;
      logic        s;
      logic        cy;
      logic        ov;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic [31:0] in_data = '0;

   logic        a_valid, a_z, a_s, a_cy, a_ov;
   logic [31:0] a_data;
   logic        b_valid, b_z, b_s, b_cy, b_ov;
   logic [31:0] b_data;

   int n_checks = 0;
   int n_fail   = 0;
   exp_t sb_q[$];

   // bench model of the flag state
   logic m_z = 0, m_s = 0, m_cy = 0, m_ov = 0;
   logic [31:0] m_last = '0;
   bit done = 0;

   always #4 clk = ~clk;

   lane_swap_unit #(.LANE_W(8), .ZDET_ARITH(1'b1)) i_lane_swap_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_data(in_data),
      .out_valid(a_valid), .out_data(a_data), .out_zero(a_z), .out_sign(a_s),
      .out_carry(a_cy), .out_ovf(a_ov));

   lane_swap_unit #(.LANE_W(8), .ZDET_ARITH(1'b0)) i_lane_swap_unit_cmp (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_data(in_data),
      .out_valid(b_valid), .out_data(b_data), .out_zero(b_z), .out_sign(b_s),
      .out_carry(b_cy), .out_ovf(b_ov));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic send(input logic [1:0] op, input logic [31:0] d, input string tag);
      exp_t e;
      logic [7:0] b0, b1, b2, b3;
      b0 = d[7:0]; b1 = d[15:8]; b2 = d[23:16]; b3 = d[31:24];
      @(negedge clk);
      in_valid = 1'b1; in_op = op; in_data = d;
      case (op)
         2'b00: e.data = {b2, b3, b0, b1};
         2'b01: e.data = {b0, b1, b2, b3};
         2'b10: e.data = {d[15:0], d[31:16]};
         default: e.data = d;
      endcase
      if (op != 2'b11) begin
         m_z = (e.data == 32'h0);
         m_s = e.data[31];
         if (op == 2'b01)
            m_cy = (e.data[7:0] == 0) || (e.data[15:8] == 0) ||
                   (e.data[23:16] == 0) || (e.data[31:24] == 0);
         else
            m_cy = (e.data[15:0] == 0) || (e.data[31:16] == 0);
         m_ov = 1'b0;
      end
      e.z = m_z; e.s = m_s; e.cy = m_cy; e.ov = m_ov; e.tag = tag;
      m_last = e.data;
      sb_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = 32'hA5A5_5A5A;
         in_op    = 2'b01;
      end
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (rst_n) begin
            if (a_valid !== b_valid) check("R10 variant valid", {31'b0, b_valid}, {31'b0, a_valid});
            if (a_valid === 1'b1) begin
               if (sb_q.size() == 0) begin
                  check("R10 unexpected valid", 32'd1, 32'd0);
               end else begin
                  exp_t e;
                  e = sb_q.pop_front();
                  check({e.tag, " data"}, a_data, e.data);
                  check({e.tag, " flags"}, {28'b0, a_z, a_s, a_cy, a_ov},
                        {28'b0, e.z, e.s, e.cy, e.ov});
                  check({e.tag, " cmp-variant data"}, b_data, e.data);
                  check({e.tag, " cmp-variant flags"}, {28'b0, b_z, b_s, b_cy, b_ov},
                        {28'b0, e.z, e.s, e.cy, e.ov});
               end
            end
         end
      end
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      // R11: reset state
      check("R11 reset valid", {31'b0, a_valid}, 32'd0);
      check("R11 reset data", a_data, 32'd0);
      check("R11 reset flags", {28'b0, a_z, a_s, a_cy, a_ov}, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      send(2'b00, 32'h1122_3344, "R1 half-lane swap");
      send(2'b00, 32'h0000_ABCD, "R8 half-lane upper zero");
      send(2'b00, 32'h1200_5678, "R8 half-lane single zero byte");
      send(2'b01, 32'h1122_3344, "R2 reversal");
      send(2'b01, 32'h1200_3456, "R7 reversal zero byte");
      send(2'b01, 32'h0101_0101, "R7 reversal ones");
      send(2'b01, 32'h0000_0100, "R7 reversal borrow chain");
      send(2'b01, 32'h8080_8080, "R6 reversal sign");
      send(2'b10, 32'h1234_ABCD, "R3 halfword swap sign");
      send(2'b10, 32'h0000_1234, "R8 halfword swap low zero");
      send(2'b10, 32'h1200_5678, "R8 halfword single zero byte");
      send(2'b01, 32'h0000_0000, "R5 zero result");
      send(2'b11, 32'hDEAD_BEEF, "R4 reserved keeps flags");
      send(2'b00, 32'h8001_7F02, "R6 half-lane sign");
      send(2'b11, 32'h0000_0000, "R4 reserved zero operand");
      send(2'b10, 32'h0000_0000, "R5 halfword zero");

      // R10: idle hold
      idle(3);
      #0;
      @(posedge clk); #2;
      check("R10 idle valid low", {31'b0, a_valid}, 32'd0);
      check("R10 idle data hold", a_data, m_last);
      check("R10 idle flags hold", {28'b0, a_z, a_s, a_cy, a_ov},
            {28'b0, m_z, m_s, m_cy, m_ov});

      // random, biased towards zero lanes
      for (int k = 0; k < 400; k++) begin
         logic [31:0] d;
         d = $urandom;
         for (int j = 0; j < 4; j++) begin
            int r;
            r = $urandom_range(0, 5);
            if (r == 0) d[j*8 +: 8] = 8'h00;
            else if (r == 1) d[j*8 +: 8] = 8'h01;
            else if (r == 2) d[j*8 +: 8] = 8'h80;
         end
         send(2'($urandom_range(0, 3)), d, "R1 R2 R3 R4 R7 R8 R9 random");
         if ($urandom_range(0, 7) == 0) idle(1);
      end
      idle(4);
      @(posedge clk); #2;
      check("R10 queue drained", sb_q.size(), 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule